// File: doc/BRIEF.md
# Comb/Bypass Mode Controller

This block decides whether a video comb filter processes its input or hands the raw signals straight through to its outputs. A bypass request pin and a polarity select pin together form the request. Bypass is requested whenever the two pins disagree. The same select pin also sets how the block leaves bypass. With the select LOW, comb processing resumes as soon as the request clears. With the select HIGH, it resumes only at the next vertical sync pulse. Entering bypass never waits for sync.

The registered mode produces four kinds of output. A stop line holds the phase-locked loop and the clock processing idle. Three path selectors each pick either the raw source or the processed one. A status flag is HIGH while combing. A separate pre-filter selector follows an enable pin that reads as HIGH when it is undriven. The request, select and vertical sync pins each pass through a flop synchroniser before use. All mode changes therefore lag the pins by `SYNC_STAGES + 1` clock edges.

Top module: `bypass_mode_ctrl`

## Requirements
- R1: Bypass is requested when `byp_req_pin` and `pol_sel_pin` differ. Equal levels (both 0 or both 1) request comb mode.
- R2: When a bypass request appears on the pins, `stop_o` goes to 1 on the third rising edge after the change (SYNC_STAGES = 2). No vertical pulse is needed.
- R3: With `pol_sel_pin` = 0, `stop_o` goes to 0 on the third rising edge after `byp_req_pin` goes to 0.
- R4: With `pol_sel_pin` = 1, once the request clears, `stop_o` stays 1 until the first rising edge of `vsync_pin` that the synchroniser shows after the request has cleared. `stop_o` then falls one edge after that rising edge is seen, which is three edges after the `vsync_pin` rise. A `vsync_pin` rise seen while bypass is still requested has no effect.
- R5: If bypass is requested again while waiting for the vertical pulse, the wait is cancelled. A pulse during that renewed request leaves `stop_o` at 1. After the request clears again, the next pulse is still needed.
- R6: If a renewed bypass request and a vertical pulse rising edge reach the controller in the same cycle, bypass wins and `stop_o` stays 1.
- R7: `sel_cvbs_o`, `sel_luma_o` and `sel_chroma_o` equal `stop_o` (1 = raw source, 0 = processed source). `pll_run_o` is the inverse of `stop_o`, so the loop and clock processing are held whenever stop is 1.
- R8: `comb_active_o` is 1 exactly when `stop_o` is 0.
- R9: `prefilt_sel_o` is 1 (pre-filtered input) when `prefilt_pin` = 1 or `prefilt_driven` = 0. It is 0 (unfiltered input) when the pin is driven to 0. This path is combinational.
- R10: While `rst_n` is 0, `stop_o` = 1 and `comb_active_o` = 0, whatever the pins do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byp_req_pin | input | 1 | Bypass request pin, asynchronous |
| pol_sel_pin | input | 1 | Polarity and resume-sync select pin, asynchronous |
| vsync_pin | input | 1 | Vertical sync pulse, asynchronous, clean digital |
| prefilt_pin | input | 1 | Pre-filter enable pin level |
| prefilt_driven | input | 1 | 0 when the pre-filter enable pin is left floating |
| stop_o | output | 1 | 1 in bypass, 0 in comb |
| pll_run_o | output | 1 | Enable for the loop and clock processing |
| sel_cvbs_o | output | 1 | Composite output selector, 1 = raw input |
| sel_luma_o | output | 1 | Luma output selector, 1 = raw luma input |
| sel_chroma_o | output | 1 | Chroma output selector, 1 = external chroma |
| prefilt_sel_o | output | 1 | 1 = pre-filtered input feeds the delay lines |
| comb_active_o | output | 1 | Status, 1 while combing |

## Verification
The interesting collision is a renewed bypass request and a vertical pulse rising edge reaching the controller in the same cycle while it waits to resume comb mode. The bench provokes this by moving `byp_req_pin` and `vsync_pin` in the same clock interval. The two pins share the same synchroniser depth, so both arrive together. Stop must stay high. A later clean pulse, after the request has cleared again, must still be needed before comb mode resumes. A second pairing, a pulse rising while bypass is still requested, is judged the same way: it must not count as the resume event.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
  typedef enum logic [1:0] {
    MODE_BYP  = 2'd0,
    MODE_WAIT = 2'd1,
    MODE_COMB = 2'd2
  } mode_e;

  localparam int NUM_PATHS = 3;
endpackage

// File: rtl/bmc_sync.sv
module bmc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/bmc_mode_fsm.sv
module bmc_mode_fsm
  import bmc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req_s,
  input  logic  sel_s,
  input  logic  vs_s,
  output mode_e mode_o
);
  mode_e mode_q, mode_d;
  logic  vs_prev_q;
  logic  vs_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vs_prev_q <= 1'b0;
    else        vs_prev_q <= vs_s;
  end

  assign vs_edge = vs_s & ~vs_prev_q;

  always_comb begin
    mode_d = mode_q;
    if (req_s) begin
      mode_d = MODE_BYP;
    end else begin
      unique case (mode_q)
        MODE_BYP:  mode_d = sel_s ? MODE_WAIT : MODE_COMB;
        MODE_WAIT: if (!sel_s || vs_edge) mode_d = MODE_COMB;
        MODE_COMB: mode_d = MODE_COMB;
        default:   mode_d = MODE_BYP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_BYP;
    else        mode_q <= mode_d;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/bmc_out_sel.sv
module bmc_out_sel
  import bmc_pkg::*;
#(
  parameter int PATHS = NUM_PATHS
) (
  input  mode_e            mode,
  input  logic             prefilt_pin,
  input  logic             prefilt_driven,
  output logic             stop,
  output logic             pll_run,
  output logic [PATHS-1:0] path_sel,
  output logic             comb_active,
  output logic             prefilt_sel
);
  assign stop        = (mode != MODE_COMB);
  assign pll_run     = ~stop;
  assign comb_active = (mode == MODE_COMB);

  for (genvar i = 0; i < PATHS; i++) begin : g_path
    assign path_sel[i] = stop;
  end

  assign prefilt_sel = prefilt_pin | ~prefilt_driven;
endmodule

// File: rtl/bypass_mode_ctrl.sv
module bypass_mode_ctrl
  import bmc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic byp_req_pin,
  input  logic pol_sel_pin,
  input  logic vsync_pin,
  input  logic prefilt_pin,
  input  logic prefilt_driven,
  output logic stop_o,
  output logic pll_run_o,
  output logic sel_cvbs_o,
  output logic sel_luma_o,
  output logic sel_chroma_o,
  output logic prefilt_sel_o,
  output logic comb_active_o
);
  localparam int PATHS = NUM_PATHS;

  logic byp_s, sel_s, vs_s, req_s;
  mode_e mode;
  logic [PATHS-1:0] path_sel;

  // Reset values form a bypass request until real pin levels arrive.
  bmc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_byp (
    .clk(clk), .rst_n(rst_n), .d(byp_req_pin), .q(byp_s));
  bmc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sel (
    .clk(clk), .rst_n(rst_n), .d(pol_sel_pin), .q(sel_s));
  bmc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_vs (
    .clk(clk), .rst_n(rst_n), .d(vsync_pin), .q(vs_s));

  assign req_s = byp_s ^ sel_s;

  bmc_mode_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_s(req_s), .sel_s(sel_s),
    .vs_s(vs_s), .mode_o(mode));

  bmc_out_sel #(.PATHS(PATHS)) u_out (
    .mode(mode), .prefilt_pin(prefilt_pin), .prefilt_driven(prefilt_driven),
    .stop(stop_o), .pll_run(pll_run_o), .path_sel(path_sel),
    .comb_active(comb_active_o), .prefilt_sel(prefilt_sel_o));

  assign sel_cvbs_o   = path_sel[0];
  assign sel_luma_o   = path_sel[1];
  assign sel_chroma_o = path_sel[2];
endmodule

// File: rtl/bmc_chk.sv
module bmc_chk (
  input logic clk,
  input logic rst_n,
  input logic req_s,
  input logic sel_s,
  input logic vs_s,
  input logic prefilt_pin,
  input logic prefilt_driven,
  input logic stop_o,
  input logic pll_run_o,
  input logic sel_cvbs_o,
  input logic sel_luma_o,
  input logic sel_chroma_o,
  input logic prefilt_sel_o,
  input logic comb_active_o
);
  // R2
  enter_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_s |=> stop_o);

  // R3
  fast_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_s && !sel_s) |=> !stop_o);

  // R4
  vsync_resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(stop_o) && $past(sel_s)) |-> ($past(vs_s) && !$past(vs_s, 2)));

  // R7
  path_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |-> (!pll_run_o && sel_cvbs_o && sel_luma_o && sel_chroma_o));

  // R8
  status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    comb_active_o != stop_o);

  always @(negedge clk) begin
    // R9
    prefilt_chk: assert (prefilt_sel_o == (prefilt_pin || !prefilt_driven));
    // R10
    if (!rst_n) reset_state_chk: assert (stop_o && !comb_active_o);
  end
endmodule

bind bypass_mode_ctrl bmc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_s(req_s), .sel_s(sel_s), .vs_s(vs_s),
  .prefilt_pin(prefilt_pin), .prefilt_driven(prefilt_driven),
  .stop_o(stop_o), .pll_run_o(pll_run_o), .sel_cvbs_o(sel_cvbs_o),
  .sel_luma_o(sel_luma_o), .sel_chroma_o(sel_chroma_o),
  .prefilt_sel_o(prefilt_sel_o), .comb_active_o(comb_active_o));

// File: tb/bypass_mode_ctrl_tb_top.sv
module bypass_mode_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byp = 1'b0, psel = 1'b0, vs = 1'b0, pf = 1'b1, pfd = 1'b1;
  logic stop, pll_run, s_cv, s_lu, s_ch, pf_sel, comb;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;
  string tag = "R10";

  always #(CLK_PERIOD/2) clk = ~clk;

  bypass_mode_ctrl #(.SYNC_STAGES(SYNC)) dut_i (
    .clk(clk), .rst_n(rst_n), .byp_req_pin(byp), .pol_sel_pin(psel),
    .vsync_pin(vs), .prefilt_pin(pf), .prefilt_driven(pfd),
    .stop_o(stop), .pll_run_o(pll_run), .sel_cvbs_o(s_cv),
    .sel_luma_o(s_lu), .sel_chroma_o(s_ch), .prefilt_sel_o(pf_sel),
    .comb_active_o(comb));

  // Reference model: pin history queue, combing flag, armed-for-vsync flag.
  typedef struct packed { logic b; logic s; logic v; } pins_t;
  pins_t hist[$];
  bit m_comb, m_armed;

  task automatic model_reset();
    hist.delete();
    for (int i = 0; i <= SYNC; i++) hist.push_back('{b:1'b1, s:1'b0, v:1'b0});
    m_comb = 0; m_armed = 0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      pins_t now_p, old_p;
      bit want_byp, edge_seen;
      now_p = hist[hist.size()-SYNC];
      old_p = hist[hist.size()-SYNC-1];
      want_byp  = now_p.b != now_p.s;
      edge_seen = now_p.v && !old_p.v;
      if (want_byp) begin
        m_comb = 0; m_armed = 0;
      end else if (!m_comb) begin
        if (!now_p.s) m_comb = 1;
        else if (m_armed && edge_seen) m_comb = 1;
        else m_armed = 1;
      end
      hist.push_back('{b:byp, s:psel, v:vs});
      void'(hist.pop_front());
    end
  end

  task automatic check(string t, logic [3:0] act, logic [3:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %b expected %b at %0t", t, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      bit e_stop;
      e_stop = !m_comb;
      if (!rst_n) check("R10", {2'b0, stop, comb}, 4'b0010);
      else        check(tag, {3'b0, stop}, {3'b0, e_stop});
      check("R7", {s_cv, s_lu, s_ch, pll_run}, {stop, stop, stop, !stop});
      check("R8", {3'b0, comb}, {3'b0, !e_stop});
      check("R9", {3'b0, pf_sel}, {3'b0, pf || !pfd});
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    miscompares++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    step(5);                       // R10: reset with comb-looking pins
    rst_n = 1'b1;
    tag = "R3"; step(8);           // both 0 -> comb without vsync
    tag = "R2"; byp = 1; step(6);  // differ -> bypass at once
    tag = "R3"; byp = 0; step(6);
    tag = "R9"; pf = 0; step(2); pfd = 0; step(2); pf = 1; pfd = 1; step(2);
    tag = "R1"; psel = 1; step(6); // 0/1 -> bypass
    tag = "R4"; vs = 1; step(2); vs = 0; step(2); // pulse during request
    byp = 1; step(12);             // 1/1 -> waits for vsync
    vs = 1; step(3); vs = 0; step(5);
    vs = 1; step(2); vs = 0; step(3); // pulse in comb: no change
    tag = "R5"; byp = 0; step(5);  // bypass again
    byp = 1; step(4);              // waiting
    byp = 0; step(3); vs = 1; step(2); vs = 0; step(3); // cancelled
    byp = 1; step(10);             // waits again, no pulse yet
    vs = 1; step(2); vs = 0; step(5);
    tag = "R6"; byp = 0; step(5); byp = 1; step(5); // waiting
    byp = 0; vs = 1; step(4);      // same-cycle collision
    byp = 1; step(6);              // vs still high, no new edge
    vs = 0; step(3); vs = 1; step(2); vs = 0; step(5);
    tag = "R1"; psel = 0; step(5); byp = 0; step(5);
    tag = "R7";
    for (int k = 0; k < 3000; k++) begin
      int r;
      r = $urandom_range(0, 15);
      byp = r[0]; psel = (r[3:1] == 3'd0) ? ~psel : psel;
      vs = ($urandom_range(0, 5) == 0);
      pf = r[2]; pfd = r[1] | r[3];
      step($urandom_range(1, 4));
    end
    finish_run();
  end
endmodule